// File: doc/BRIEF.md
# GPIO Interrupt Sense and Mask Unit

This block turns the synchronized levels of a bank of general-purpose pins into interrupt status and a single interrupt request. Each pin that the surrounding bank has placed in interrupt mode is sensed according to three configuration bits: whether its status tracks a level or latches an edge, which polarity counts as active, and whether both transitions count. Edge-sensed status stays pending until software clears it with a write-1 pulse. Level-sensed status simply follows the qualified pin level one cycle later.

A per-pin enable mask sits between status and the request line. It has two write ports: one that can only clear enable bits, by writing a 0, and one that can only set them, by writing a 1. Software can therefore enable or disable a single pin without a read-modify-write. The interrupt output is the OR over all pins of status ANDed with enable. Registers are reached over a plain 32-bit write strobe and a combinational read port.

A build-time option removes the both-edge register for banks that do not need it. With the option off, that register reads as zero and ignores writes.

Top module: `gpirq_unit`

## Requirements
- R1: After reset, the status (0x10), enable (0x18), polarity (0x20), sense-select (0x24) and both-edge (0x4C) registers all read 0, and `irq_out` is low.
- R2: With sense-select bit 0 (level), the status bit equals the pin level XOR the polarity bit, one clock after the pin is sampled. Polarity 0 means active-high and 1 means active-low. Writing the clear register does not hold a level-sensed bit at 0.
- R3: With sense-select bit 1 (edge) and both-edge bit 0, the status bit is set by a 0-to-1 pin change between consecutive cycles when polarity is 0, and by a 1-to-0 change when polarity is 1.
- R4: With sense-select bit 1 and both-edge bit 1, either pin transition sets the status bit, whatever the polarity bit holds.
- R5: An edge-sensed status bit stays set after the pin returns. Writing 1 to that bit at 0x14 clears it, and 0 bits in the same write leave other pending bits set.
- R6: When an edge arrives in the same cycle as a clear write for that pin, the bit ends up set.
- R7: Writing the enable register at 0x18 clears each enable bit whose written bit is 0 and leaves the bits written 1 unchanged. Writing 1 at 0x1C sets the matching enable bits. Offset 0x1C reads 0.
- R8: `irq_out` is high exactly when some pin has both its status bit and its enable bit set, in the same cycle that the status or enable changes.
- R9: A pin whose `irq_mode` bit is 0 never raises status, and its status bit reads 0 one clock after the mode bit drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_lvl | input | 32 | Synchronized pin levels |
| irq_mode | input | 32 | Per-pin interrupt-mode select from the bank |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is an edge that arrives in exactly the cycle that software's clear write takes effect. The bench therefore drives the pin change and the clear strobe on the same falling clock edge, so both meet the same rising edge. A second hard case is the both-edge mode with polarity set to 1, where a design that still obeys polarity would lose one of the two transitions. The vector table covers that case with every transition direction under both polarity settings.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
   localparam int unsigned OFS_STAT   = 'h10;
   localparam int unsigned OFS_CLR    = 'h14;
   localparam int unsigned OFS_ENA    = 'h18;
   localparam int unsigned OFS_UNMASK = 'h1C;
   localparam int unsigned OFS_POL    = 'h20;
   localparam int unsigned OFS_SENSE  = 'h24;
   localparam int unsigned OFS_BOTH   = 'h4C;
   localparam int unsigned OFS_TOP    = 'h4C;
endpackage

// File: rtl/gpirq_cfg.sv
module gpirq_cfg
   import gpirq_pkg::*;
#(
   parameter int NPIN     = 32,
   parameter int DW       = 32,
   parameter int AW       = 8,
   parameter bit HAS_BOTH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [AW-1:0]   addr_i,
   input  logic [DW-1:0]   wdata_i,
   input  logic [NPIN-1:0] stat_i,
   output logic [NPIN-1:0] pol_o,
   output logic [NPIN-1:0] sense_o,
   output logic [NPIN-1:0] both_o,
   output logic [NPIN-1:0] ena_o,
   output logic [DW-1:0]   rdata_o
);
   logic [NPIN-1:0] wbits;
   logic [NPIN-1:0] pol_q, sense_q, ena_q;

   assign wbits = wdata_i[NPIN-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q   <= '0;
         sense_q <= '0;
         ena_q   <= '0;
      end else if (wr_i) begin
         if (addr_i == AW'(OFS_POL))    pol_q   <= wbits;
         if (addr_i == AW'(OFS_SENSE))  sense_q <= wbits;
         if (addr_i == AW'(OFS_ENA))    ena_q   <= ena_q & wbits;
         if (addr_i == AW'(OFS_UNMASK)) ena_q   <= ena_q | wbits;
      end
   end

   generate
      if (HAS_BOTH) begin : g_both
         logic [NPIN-1:0] both_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                both_q <= '0;
            else if (wr_i && addr_i == AW'(OFS_BOTH)) both_q <= wbits;
         end
         assign both_o = both_q;
      end else begin : g_no_both
         assign both_o = '0;
      end
   endgenerate

   assign pol_o   = pol_q;
   assign sense_o = sense_q;
   assign ena_o   = ena_q;

   always_comb begin
      rdata_o = '0;
      if (addr_i == AW'(OFS_STAT))  rdata_o = DW'(stat_i);
      if (addr_i == AW'(OFS_ENA))   rdata_o = DW'(ena_q);
      if (addr_i == AW'(OFS_POL))   rdata_o = DW'(pol_q);
      if (addr_i == AW'(OFS_SENSE)) rdata_o = DW'(sense_q);
      if (addr_i == AW'(OFS_BOTH))  rdata_o = DW'(both_o);
   end

   // R7
   ena_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == AW'(OFS_ENA)) |=> ena_q == ($past(ena_q) & $past(wbits)));
   // R7
   ena_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == AW'(OFS_UNMASK)) |=> ena_q == ($past(ena_q) | $past(wbits)));
endmodule

// File: rtl/gpirq_sense.sv
module gpirq_sense #(
   parameter int NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_i,
   input  logic [NPIN-1:0] mode_i,
   input  logic [NPIN-1:0] pol_i,
   input  logic [NPIN-1:0] sense_i,
   input  logic [NPIN-1:0] both_i,
   input  logic [NPIN-1:0] clr_i,
   output logic [NPIN-1:0] stat_o
);
   logic [NPIN-1:0] prev_q, stat_q, nxt_v;

   generate
      for (genvar g = 0; g < NPIN; g++) begin : g_pin
         logic rise, fall, hit, nxt;
         always_comb begin
            rise = pin_i[g] & ~prev_q[g];
            fall = ~pin_i[g] & prev_q[g];
            if (sense_i[g]) begin
               if (both_i[g])     hit = rise | fall;
               else if (pol_i[g]) hit = fall;
               else               hit = rise;
               nxt = hit | (stat_q[g] & ~clr_i[g]);
            end else begin
               hit = pin_i[g] ^ pol_i[g];
               nxt = hit;
            end
            nxt = nxt & mode_i[g];
         end
         assign nxt_v[g] = nxt;

         // R9
         mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_i[g] |=> !stat_q[g]);
         // R5
         edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i[g] && sense_i[g] && stat_q[g] && !clr_i[g]) |=> stat_q[g]);
         // R6
         clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i[g] && sense_i[g] && !both_i[g] && !pol_i[g] && clr_i[g]
             && pin_i[g] && !prev_q[g]) |=> stat_q[g]);
         // R2
         lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i[g] && !sense_i[g]) |=> stat_q[g] == $past(pin_i[g] ^ pol_i[g]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= pin_i;
         stat_q <= nxt_v;
      end
   end

   assign stat_o = stat_q;
endmodule

// File: rtl/gpirq_unit.sv
module gpirq_unit
   import gpirq_pkg::*;
#(
   parameter int NPIN     = 32,
   parameter int DW       = 32,
   parameter int AW       = 8,
   parameter bit HAS_BOTH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   input  logic [NPIN-1:0] pin_lvl,
   input  logic [NPIN-1:0] irq_mode,
   output logic            irq_out
);
   generate
      if (NPIN < 1 || NPIN > DW) begin : g_bad_npin
         $error("gpirq_unit: NPIN must lie in 1..DW");
      end
      if ((2 ** AW) <= OFS_TOP) begin : g_bad_aw
         $error("gpirq_unit: AW too narrow for the register offsets");
      end
   endgenerate

   logic [NPIN-1:0] pol, sense, both, ena, stat, clr;

   assign clr = (reg_wr && reg_addr == AW'(OFS_CLR)) ? reg_wdata[NPIN-1:0] : '0;

   gpirq_cfg #(.NPIN(NPIN), .DW(DW), .AW(AW), .HAS_BOTH(HAS_BOTH)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .stat_i(stat), .pol_o(pol), .sense_o(sense),
      .both_o(both), .ena_o(ena), .rdata_o(reg_rdata)
   );

   gpirq_sense #(.NPIN(NPIN)) u_sense (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_lvl), .mode_i(irq_mode),
      .pol_i(pol), .sense_i(sense), .both_i(both), .clr_i(clr), .stat_o(stat)
   );

   assign irq_out = |(stat & ena);

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ena == '0) |-> !irq_out);
   // R1
   rst_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (stat == '0 && ena == '0));
endmodule

// File: tb/sim_gpirq_unit.sv
module sim_gpirq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] pin_lvl = '0;
   logic [31:0] irq_mode = '0;
   logic        irq_out;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   gpirq_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_lvl(pin_lvl),
      .irq_mode(irq_mode), .irq_out(irq_out)
   );

   // fields: [5] polarity, [4] edge sense, [3] both edges, [2] pin before, [1] pin after, [0] expected status
   localparam logic [5:0] VEC [14] = '{
      6'b000_011, 6'b000_100, 6'b100_001, 6'b100_010,
      6'b010_011, 6'b010_100, 6'b010_110, 6'b110_101,
      6'b110_010, 6'b011_011, 6'b011_101, 6'b111_011,
      6'b111_101, 6'b011_110
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      rd(8'h10, v); check("R1 status", v, 0);
      rd(8'h18, v); check("R1 enable", v, 0);
      rd(8'h20, v); check("R1 polarity", v, 0);
      rd(8'h24, v); check("R1 sense", v, 0);
      rd(8'h4C, v); check("R1 both", v, 0);
      check("R1 irq", {31'd0, irq_out}, 0);

      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h18, v); check("R7 set all", v, 32'hFFFF_FFFF);
      rd(8'h1C, v); check("R7 unmask reads 0", v, 0);

      // vector table
      for (int k = 0; k < 14; k++) begin
         automatic int p = (k * 5 + 1) % 32;
         automatic logic [5:0] t = VEC[k];
         automatic string tag = t[4] ? (t[3] ? "R4" : "R3") : "R2";
         pin_lvl  = {31'd0, t[2]} << p;
         irq_mode = 32'd1 << p;
         wr(8'h20, {31'd0, t[5]} << p);
         wr(8'h24, {31'd0, t[4]} << p);
         wr(8'h4C, {31'd0, t[3]} << p);
         tick();
         wr(8'h14, 32'd1 << p);
         pin_lvl = {31'd0, t[1]} << p;
         tick();
         rd(8'h10, v);
         check(tag, v, {31'd0, t[0]} << p);
         check("R8 irq follows", {31'd0, irq_out}, {31'd0, t[0]});
      end

      // R5 latching and clear, rising edge on pins 4 and 9
      irq_mode = 32'h0000_0210;
      pin_lvl = 0;
      wr(8'h20, 0); wr(8'h24, 32'h0000_0210); wr(8'h4C, 0);
      tick();
      wr(8'h14, 32'hFFFF_FFFF);
      pin_lvl = 32'h0000_0210; tick();
      pin_lvl = 0; tick(); tick();
      rd(8'h10, v); check("R5 latched", v, 32'h0000_0210);
      wr(8'h14, 32'h0000_0010);
      rd(8'h10, v); check("R5 partial clear", v, 32'h0000_0200);
      wr(8'h14, 32'h0000_0200);
      rd(8'h10, v); check("R5 cleared", v, 0);

      // R6 edge coinciding with clear on pin 4
      pin_lvl = 32'h0000_0010; tick();
      pin_lvl = 0; tick();
      rd(8'h10, v); check("R6 pre", v, 32'h0000_0010);
      pin_lvl = 32'h0000_0010;
      wr(8'h14, 32'h0000_0010);
      rd(8'h10, v); check("R6 set wins", v, 32'h0000_0010);

      // R9 mode drop clears, mode low blocks
      irq_mode = 32'h0000_0200;
      tick();
      rd(8'h10, v); check("R9 mode drop", v, 0);
      pin_lvl = 0; tick();
      pin_lvl = 32'h0000_0010; tick();
      rd(8'h10, v); check("R9 edge ignored", v, 0);

      // R2 level bit not held by clear
      irq_mode = 32'h0000_0008;
      wr(8'h24, 0); wr(8'h20, 0);
      pin_lvl = 32'h0000_0008; tick();
      wr(8'h14, 32'h0000_0008);
      rd(8'h10, v); check("R2 clear no effect", v, 32'h0000_0008);

      // R7 single-bit disable via enable write, 1 bits no effect
      wr(8'h18, ~32'h0000_0008);
      rd(8'h18, v); check("R7 clear one", v, ~32'h0000_0008);
      check("R8 masked", {31'd0, irq_out}, 0);
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, v); check("R7 ones no effect", v, ~32'h0000_0008);
      wr(8'h1C, 32'h0000_0008);
      check("R8 unmasked", {31'd0, irq_out}, 1);
      wr(8'h18, 0);
      check("R8 all masked", {31'd0, irq_out}, 0);
      report();
   end
endmodule